// File: doc/BRIEF.md
# Hardened Serial Write Sequencer for Shared Current-Output DAC Bus

This block drives a three-wire serial bus: one data line and one clock line that all devices share, plus one active-low strobe per device. Three current-output DACs and one ADC sit on the bus. A host pulses `start` with a device index and a 16-bit code. For a DAC index, the block sends a hardened update: a few don't-care preamble clocks, then a 17-bit word. The word is a leading operating-mode bit (alarm-current operation) followed by the code, shifted MSB first. The block then pulses the device's strobe low to commit the word. After a guard interval it sends the identical word and strobe once more. If the first update is corrupted by a lost clock, the second one overwrites it straight away.

For the ADC index, the block lowers the ADC select and clocks out the upper code bits. It then raises the select and sends free-running flush clocks on the shared clock line before it reports completion. The clock high and low phases have separate cycle counts, so the block can produce the slow, asymmetric clock that optically isolated links need. Every timing value is a parameter counted in system clock cycles.

Top module: `serdac_seq`

## Requirements
- R1: The last 17 bits sampled on rising `sclk` before a DAC strobe falls are the mode bit (`ALARM_BIT`, default 1) followed by `code[15:0]`, MSB first.
- R2: `sdo` changes only while `sclk` is low and stays stable through each high phase. When not busy, `sclk` and `sdo` are low and every strobe is high.
- R3: Each `sclk` high phase lasts exactly `HI_CYC` cycles. Each low phase lasts at least `LO_CYC` cycles, and exactly `LO_CYC` inside a burst.
- R4: The first frame of a DAC write has `DUMMY_CLKS` preamble clocks before its 17 data clocks. The repeat frame has exactly 17 clocks.
- R5: Index i drives `lat_n[i]`. After the last data clock, the selected DAC strobe goes low for exactly `LATCH_HOLD` cycles. At most one strobe is low at a time, and `sclk` stays low while any strobe is low.
- R6: Every DAC request produces exactly two strobe pulses on the requested device, both committing the same word.
- R7: From a DAC strobe rising to the next rising `sclk`, at least `GUARD_CYC + LO_CYC` cycles pass.
- R8: Index 3 is the ADC. `lat_n[3]` is held low for `ADC_BITS` clocks that carry `code[15:8]` MSB first. It then rises, and exactly `FLUSH_CLKS` clocks follow with it high before `done`.
- R9: `busy` rises in the cycle after an accepted `start`. `done` is a single-cycle pulse with `busy` low, and no clock follows the final strobe of a DAC write before `done`.
- R10: A `start` that arrives while `busy` is high has no effect. The committed words, the strobe counts and the number of `done` pulses match the original request alone.
- R11: During and right after reset, `sclk`=0, `sdo`=0, `lat_n`=all ones, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled only when idle |
| dev_sel | input | 2 | Target device index (0..2 DACs, 3 ADC) |
| code | input | 16 | DAC code, or ADC command bits in [15:8] |
| busy | output | 1 | High while a request is in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Shared serial clock, idles low |
| sdo | output | 1 | Shared serial data |
| lat_n | output | 4 | Per-device active-low strobe/select |

## Verification
Corruption inside the block shows up at the ports within one frame. A bit counter that is off by one shifts the word captured at the strobe edge, which shows as a doubled or halved code, and it changes the clock count before the strobe. A phase counter error shows up at the next `sclk` edge as a wrong high width. A missing repeat pass or a skipped guard changes the strobe count or the strobe-to-clock gap before `done`. A state machine that accepts a request while busy commits a different word or produces an extra `done` within the same transaction. The bench therefore rebuilds every word, clock count, width and gap from the bus pins alone. It sweeps the code with walking ones and fixed patterns across all three DACs and the ADC.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
    localparam int CODE_W = 16;
    localparam int WORD_W = CODE_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SHIFT,
        ST_HOLD,
        ST_GUARD,
        ST_ADC,
        ST_FLUSH
    } seq_st_e;
endpackage

// File: rtl/serdac_bit_timer.sv
module serdac_bit_timer #(
    parameter int HI_CYC = 2500,
    parameter int LO_CYC = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic slot_end
);
    localparam int CMAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int CW   = (CMAX > 1) ? $clog2(CMAX) : 1;

    typedef struct packed {
        logic          hi;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_q, t_d;

    // low phase first, then high phase; slot ends on the last high cycle
    always_comb begin
        t_d      = t_q;
        slot_end = 1'b0;
        if (!run) begin
            t_d.hi  = 1'b0;
            t_d.cnt = '0;
        end else if (!t_q.hi) begin
            if (t_q.cnt == CW'(LO_CYC - 1)) begin
                t_d.hi  = 1'b1;
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end else begin
            if (t_q.cnt == CW'(HI_CYC - 1)) begin
                t_d.hi   = 1'b0;
                t_d.cnt  = '0;
                slot_end = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign sclk = t_q.hi;

    AST_STOP_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> !t_q.hi) else $error("clock stopped mid high phase"); // R3
endmodule

// File: rtl/serdac_sel_decode.sv
module serdac_sel_decode #(
    parameter int NDEV = 4,
    parameter int IDXW = 2
) (
    input  logic [IDXW-1:0] dev,
    input  logic            strobe,
    output logic [NDEV-1:0] sel_n
);
    for (genvar i = 0; i < NDEV; i++) begin : g_sel
        assign sel_n[i] = ~(strobe && (dev == IDXW'(i)));
    end
endmodule

// File: rtl/serdac_seq.sv
module serdac_seq
    import serdac_pkg::*;
#(
    parameter int   NDEV       = 4,
    parameter int   ADC_IDX    = 3,
    parameter int   HI_CYC     = 2500,
    parameter int   LO_CYC     = 6250,
    parameter int   DUMMY_CLKS = 3,
    parameter int   LATCH_HOLD = 500,
    parameter int   GUARD_CYC  = 250000,
    parameter int   FLUSH_CLKS = 5,
    parameter int   ADC_BITS   = 8,
    parameter logic ALARM_BIT  = 1'b1,
    localparam int  IDXW       = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDXW-1:0]   dev_sel,
    input  logic [CODE_W-1:0] code,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sdo,
    output logic [NDEV-1:0]   lat_n
);
    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int BMAX = imax(imax(WORD_W, DUMMY_CLKS), imax(ADC_BITS, FLUSH_CLKS));
    localparam int BW   = $clog2(BMAX + 1);
    localparam int WMAX = imax(LATCH_HOLD, GUARD_CYC);
    localparam int WW   = $clog2(WMAX + 1);

    typedef struct packed {
        seq_st_e           st;
        logic [IDXW-1:0]   dev;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] sh;
        logic [BW-1:0]     bits;
        logic [WW-1:0]     wt;
        logic              second;
        logic              done;
    } regs_t;

    regs_t r_q, r_d;
    logic  run, slot_end, strobe;

    assign run = (r_q.st == ST_PRE) || (r_q.st == ST_SHIFT) ||
                 (r_q.st == ST_ADC) || (r_q.st == ST_FLUSH);
    assign strobe = (r_q.st == ST_HOLD) || (r_q.st == ST_ADC);

    serdac_bit_timer #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (sclk),
        .slot_end (slot_end)
    );

    serdac_sel_decode #(.NDEV(NDEV), .IDXW(IDXW)) u_decode (
        .dev    (r_q.dev),
        .strobe (strobe),
        .sel_n  (lat_n)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.dev    = dev_sel;
                    r_d.second = 1'b0;
                    r_d.bits   = '0;
                    r_d.wt     = '0;
                    if (dev_sel == IDXW'(ADC_IDX)) begin
                        r_d.sh = {code, 1'b0};
                        r_d.st = ST_ADC;
                    end else begin
                        r_d.word = {ALARM_BIT, code};
                        r_d.sh   = {ALARM_BIT, code};
                        r_d.st   = (DUMMY_CLKS > 0) ? ST_PRE : ST_SHIFT;
                    end
                end
            end
            ST_PRE: begin
                if (slot_end) begin
                    if (r_q.bits == BW'(DUMMY_CLKS - 1)) begin
                        r_d.bits = '0;
                        r_d.st   = ST_SHIFT;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (slot_end) begin
                    r_d.sh = {r_q.sh[WORD_W-2:0], 1'b0};
                    if (r_q.bits == BW'(WORD_W - 1)) begin
                        r_d.bits = '0;
                        r_d.wt   = '0;
                        r_d.st   = ST_HOLD;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (r_q.wt == WW'(LATCH_HOLD - 1)) begin
                    r_d.wt = '0;
                    r_d.st = ST_GUARD;
                end else begin
                    r_d.wt = r_q.wt + 1'b1;
                end
            end
            ST_GUARD: begin
                if (r_q.wt == WW'(GUARD_CYC - 1)) begin
                    r_d.wt = '0;
                    if (r_q.second) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.second = 1'b1;
                        r_d.sh     = r_q.word;
                        r_d.st     = ST_SHIFT;
                    end
                end else begin
                    r_d.wt = r_q.wt + 1'b1;
                end
            end
            ST_ADC: begin
                if (slot_end) begin
                    r_d.sh = {r_q.sh[WORD_W-2:0], 1'b0};
                    if (r_q.bits == BW'(ADC_BITS - 1)) begin
                        r_d.bits = '0;
                        if (FLUSH_CLKS > 0) begin
                            r_d.st = ST_FLUSH;
                        end else begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                if (slot_end) begin
                    if (r_q.bits == BW'(FLUSH_CLKS - 1)) begin
                        r_d.bits = '0;
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.bits = r_q.bits + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;
    assign sdo  = ((r_q.st == ST_SHIFT) || (r_q.st == ST_ADC)) ? r_q.sh[WORD_W-1] : 1'b0;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdo && (&lat_n))) else $error("bus active while idle"); // R2
    AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> (!sclk || $stable(sdo))) else $error("data moved during high phase"); // R2
    AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~lat_n)) else $error("more than one strobe low"); // R5
    AST_NO_CLK_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (~lat_n[ADC_IDX] == 1'b0 && !(&lat_n)) |-> !sclk) else $error("clock during DAC strobe"); // R5
    AST_TWO_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_GUARD && r_q.st == ST_IDLE) |-> $past(r_q.second)) else $error("single frame write"); // R6
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done wider than one cycle"); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (r_q.dev == $past(r_q.dev))) else $error("request taken while busy"); // R10
endmodule

// File: tb/serdac_seq_tb.sv
module serdac_seq_tb;
    localparam int HI   = 2;
    localparam int LO   = 3;
    localparam int DUM  = 3;
    localparam int HOLD = 4;
    localparam int GRD  = 6;
    localparam int FL   = 5;
    localparam int AB   = 8;
    localparam int ADCI = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  dev_sel = '0;
    logic [15:0] code = '0;
    logic        busy, done, sclk, sdo;
    logic [3:0]  lat_n;

    always #10 clk = ~clk;

    serdac_seq #(
        .NDEV(4), .ADC_IDX(ADCI), .HI_CYC(HI), .LO_CYC(LO), .DUMMY_CLKS(DUM),
        .LATCH_HOLD(HOLD), .GUARD_CYC(GRD), .FLUSH_CLKS(FL), .ADC_BITS(AB), .ALARM_BIT(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel), .code(code),
        .busy(busy), .done(done), .sclk(sclk), .sdo(sdo), .lat_n(lat_n)
    );

    int total = 0;
    int bad   = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus monitor, sampled on the falling system clock edge
    int          cyc = 0, nclk = 0, t_rise = 0, t_fall = 0, t_lfall = 0, t_lrise = 0;
    bit          gap_pend = 0;
    logic [31:0] hist = '0;
    logic [16:0] ev_word [64];
    int          ev_clk  [64];
    int          nev = 0;
    int          n_lat [4] = '{0, 0, 0, 0};
    int          n_done = 0, done_clk = 0, adc_clk = 0;
    logic [7:0]  adc_bits = '0;
    logic        sclk_p = 1'b0;
    logic [3:0]  lat_p = 4'hF;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sclk && !sclk_p) begin
                hist = {hist[30:0], sdo};
                nclk++;
                chk(cyc - t_fall >= LO, "R3 low width", cyc - t_fall, LO);
                if (gap_pend) begin
                    chk(cyc - t_lrise >= GRD + LO, "R7 guard gap", cyc - t_lrise, GRD + LO);
                    gap_pend = 0;
                end
                t_rise = cyc;
            end
            if (!sclk && sclk_p) begin
                chk(cyc - t_rise == HI, "R3 high width", cyc - t_rise, HI);
                t_fall = cyc;
            end
            for (int i = 0; i < 4; i++) begin
                if (lat_p[i] && !lat_n[i]) begin
                    n_lat[i]++;
                    if (i != ADCI) begin
                        ev_word[nev % 64] = hist[16:0];
                        ev_clk[nev % 64]  = nclk;
                        nev++;
                        t_lfall = cyc;
                    end
                    nclk = 0;
                end
                if (!lat_p[i] && lat_n[i]) begin
                    if (i != ADCI) begin
                        chk(cyc - t_lfall == HOLD, "R5 strobe hold", cyc - t_lfall, HOLD);
                        gap_pend = 1;
                        t_lrise  = cyc;
                    end else begin
                        adc_clk  = nclk;
                        adc_bits = hist[7:0];
                        nclk     = 0;
                    end
                end
            end
            if (done) begin
                n_done++;
                done_clk = nclk;
                nclk     = 0;
                gap_pend = 0;
            end
        end
        sclk_p = sclk;
        lat_p  = lat_n;
    end

    task automatic wait_done(input int nd0);
        int w = 0;
        while (n_done == nd0 && w < 20000) begin
            @(negedge clk); #1;
            w++;
        end
        chk(n_done != nd0, "R9 completion", n_done, nd0 + 1);
    endtask

    task automatic kick(input logic [1:0] d, input logic [15:0] c);
        @(negedge clk); #1;
        start = 1'b1; dev_sel = d; code = c;
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic dac_write(input logic [1:0] d, input logic [15:0] c, input bit spam);
        int nev0 = nev;
        int nd0  = n_done;
        int nl0 [4];
        logic [16:0] expw = {1'b1, c};
        nl0 = n_lat;
        kick(d, c);
        chk(busy == 1'b1, "R9 busy rises", busy, 1);
        if (spam) begin
            repeat (7) @(negedge clk);
            #1;
            kick(d ^ 2'd1, ~c);
            kick(2'd3, c ^ 16'h00FF);
        end
        wait_done(nd0);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        chk(nev - nev0 == 2, "R6 frame count", nev - nev0, 2);
        chk(ev_word[nev0 % 64] == expw, "R1 first word", ev_word[nev0 % 64], expw);
        chk(ev_word[(nev0 + 1) % 64] == expw, "R6 repeat word", ev_word[(nev0 + 1) % 64], expw);
        chk(ev_clk[nev0 % 64] == DUM + 17, "R4 first frame clocks", ev_clk[nev0 % 64], DUM + 17);
        chk(ev_clk[(nev0 + 1) % 64] == 17, "R4 repeat frame clocks", ev_clk[(nev0 + 1) % 64], 17);
        for (int i = 0; i < 4; i++) begin
            chk(n_lat[i] - nl0[i] == ((i == int'(d)) ? 2 : 0), "R5 strobe target",
                n_lat[i] - nl0[i], (i == int'(d)) ? 2 : 0);
        end
        chk(done_clk == 0, "R9 no clock after strobe", done_clk, 0);
        if (spam) begin
            repeat (30) @(negedge clk);
            #1;
            chk(n_done == nd0 + 1, "R10 single done", n_done, nd0 + 1);
            chk(nev == nev0 + 2 && busy == 1'b0, "R10 no extra frame", nev - nev0, 2);
        end
        chk(sclk == 1'b0 && sdo == 1'b0, "R2 idle bus low", {sclk, sdo}, 0);
    endtask

    task automatic adc_access(input logic [15:0] c);
        int nev0 = nev;
        int nd0  = n_done;
        int nl0 [4];
        nl0 = n_lat;
        kick(2'd3, c);
        wait_done(nd0);
        chk(adc_clk == AB, "R8 select clocks", adc_clk, AB);
        chk(adc_bits == c[15:8], "R8 command bits", adc_bits, c[15:8]);
        chk(done_clk == FL, "R8 flush clocks", done_clk, FL);
        chk(n_lat[3] - nl0[3] == 1, "R8 select pulses", n_lat[3] - nl0[3], 1);
        chk(nev == nev0, "R8 no DAC strobe", nev - nev0, 0);
        chk(lat_n == 4'hF, "R8 select released", lat_n, 4'hF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk({sclk, sdo, busy, done} == 4'b0, "R11 reset outputs", {sclk, sdo, busy, done}, 0);
        chk(lat_n == 4'hF, "R11 reset strobes", lat_n, 4'hF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk({sclk, sdo, busy, done} == 4'b0, "R11 after release", {sclk, sdo, busy, done}, 0);
        chk(lat_n == 4'hF, "R11 strobes after release", lat_n, 4'hF);

        for (int d = 0; d < 3; d++) begin
            dac_write(2'(d), 16'h0000, 0);
            dac_write(2'(d), 16'hFFFF, 0);
            dac_write(2'(d), 16'hA5A5, 0);
            dac_write(2'(d), 16'h5A5A, 0);
        end
        for (int b = 0; b < 16; b++) begin
            dac_write(2'(b % 3), 16'(1 << b), 0);
        end
        adc_access(16'hA500);
        dac_write(2'd1, 16'hB5C2, 0);
        adc_access(16'h3C00);
        adc_access(16'h0100);
        dac_write(2'd0, 16'h8001, 0);
        dac_write(2'd1, 16'h1234, 1);
        dac_write(2'd2, 16'hC3C3, 1);
        adc_access(16'hFF00);
        dac_write(2'd2, 16'h7FFF, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule